// File: doc/BRIEF.md
# Cache-Aware Lookup Dispatch Scheduler

This block sits in front of a bank of parallel longest-prefix-match pipelines. Every cycle it accepts up to `W` destination addresses, one per input slot. Each address is checked against a small fully associative result cache and used to read a queue-selection table indexed by its leading bits. Packets that miss the cache are steered to the input queue that owns their subtrie. Packets that hit already have their next hop, so they are steered to the least-loaded queue and pass through the pipeline without a lookup.

Each dispatched packet carries three values. The first is the chosen queue. The second is a delay value that the output side uses to hold a hit back until the packets of its flow that took the long path have caught up. The third is an arrival tag taken from its input slot. The scheduler also tracks how full each queue is. It back-pressures the inputs when a target queue is full. It learns new cache entries from pipeline results and applies route-update refresh or invalidation to them.

Top module: `lpm_dispatch`

## Requirements
- R1: A packet that misses the cache goes to the queue number stored in the selection table at index `in_addr[AW-1 -: IB]`. The table entry at that index is written by `tbl_we`/`tbl_idx`/`tbl_queue`, and a write takes effect for lookups from the next cycle on.
- R2: A packet that hits the cache goes to the queue with the lowest occupancy. On a tie the lowest queue number wins. The occupancy seen by a slot includes the packets accepted from lower-numbered slots in the same cycle.
- R3: A hit carries delay = occupancy of its table-selected queue minus the lowest occupancy, both taken as seen by that slot before its own packet is counted. A miss carries delay 0 and next hop 0. A hit carries the cached next hop.
- R4: An accepted slot `s` produces `out_valid[s]` exactly one cycle later, with tag `s+1`. A slot not accepted produces no output in that cycle.
- R5: `fill_valid` loads `fill_addr`/`fill_hop` into the cache, so the address hits from the next cycle on. If the address is already cached, only its next hop is replaced and no second entry is made.
- R6: The cache holds `CE` entries. A fill into a full cache evicts the least recently used entry. A use is a hit by an accepted packet or a fill, and uses in one cycle are ordered by slot, then fill. A free entry is always taken before any eviction.
- R7: `upd_valid` with `upd_kill`=1 removes a cached `upd_addr`. With `upd_kill`=0 it replaces that entry's next hop with `upd_hop`. An update does not count as a use, and an update for an address that is not cached has no effect. An update is applied after a fill in the same cycle.
- R8: Each queue's occupancy rises by one per accepted packet and falls by one when its `deq` bit is high and it was non-empty at the start of the cycle. A queue holding `QD` packets, counting same-cycle acceptances, takes no more packets.
- R9: A slot is not ready when its target queue is full. Every higher-numbered slot is then also not ready in that cycle. A refused packet changes no occupancy and no cache state.
- R10: After reset no output is valid, all queues are empty, the cache is empty, and every table entry selects queue 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | W | Packet present per slot |
| in_ready | output | W | Slot accepted this cycle when valid |
| in_addr | input | W*AW | Destination address per slot |
| deq | input | NQ | Pipeline removed one packet from each flagged queue |
| fill_valid | input | 1 | Pipeline result to learn into the cache |
| fill_addr | input | AW | Address of the learned result |
| fill_hop | input | HW | Next hop of the learned result |
| upd_valid | input | 1 | Route update touching a cached address |
| upd_kill | input | 1 | 1 = invalidate, 0 = refresh next hop |
| upd_addr | input | AW | Address the update applies to |
| upd_hop | input | HW | New next hop for a refresh |
| tbl_we | input | 1 | Write one selection-table entry |
| tbl_idx | input | IB | Table index to write |
| tbl_queue | input | log2(NQ) | Queue number to store |
| out_valid | output | W | Dispatch result valid per slot |
| out_hit | output | W | Result came from the cache |
| out_queue | output | W*log2(NQ) | Chosen queue per slot |
| out_hop | output | W*HW | Next hop (hits only, else 0) |
| out_delay | output | W*log2(QD+1) | Reorder delay per slot |
| out_tag | output | W*log2(W+1) | Arrival tag per slot |

## Verification
The bench builds the block with four slots, four queues, a four-entry cache and a queue depth of six, keeping the default 32-bit address and 8-bit table index. Pairing four entries with a ten-address pool makes LRU evictions, refills and refresh/invalidate hits frequent. Pairing a depth of six with a low drain rate drives queues to full, so back-pressure, blocked later slots and unequal occupancies (non-zero delays and tie-breaking) all occur often. A first phase runs with the table still at its reset contents, before any table writes.

// File: rtl/lpm_dispatch_pkg.sv
package lpm_dispatch_pkg;

  // Reorder hold for a hit: how far its home queue lags the emptiest one.
  function automatic int unsigned occ_gap(input int unsigned home_occ,
                                          input int unsigned low_occ);
    return home_occ - low_occ;
  endfunction

  // Arrival tag of an input slot (slots count from one).
  function automatic int unsigned slot_tag(input int unsigned slot);
    return slot + 1;
  endfunction

endpackage

// File: rtl/lpm_dsp_cache.sv
module lpm_dsp_cache #(
  parameter int W  = 4,
  parameter int AW = 32,
  parameter int HW = 8,
  parameter int CE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W*AW-1:0] look_addr,
  output logic [W-1:0]    look_hit,
  output logic [W*HW-1:0] look_hop,
  input  logic [W-1:0]    touch,
  input  logic            fill_valid,
  input  logic [AW-1:0]   fill_addr,
  input  logic [HW-1:0]   fill_hop,
  input  logic            upd_valid,
  input  logic            upd_kill,
  input  logic [AW-1:0]   upd_addr,
  input  logic [HW-1:0]   upd_hop
);
  localparam int CW = (CE > 1) ? $clog2(CE) : 1;

  logic [CE-1:0] v_q, v_n;
  logic [AW-1:0] a_q [CE];
  logic [AW-1:0] a_n [CE];
  logic [HW-1:0] h_q [CE];
  logic [HW-1:0] h_n [CE];
  logic [CW-1:0] age_q [CE];
  logic [CW-1:0] age_n [CE];
  logic [CW-1:0] hit_ent [W];

  // Match against the state held at the start of the cycle.
  always_comb begin
    look_hit = '0;
    look_hop = '0;
    for (int s = 0; s < W; s++) begin
      hit_ent[s] = '0;
      for (int e = 0; e < CE; e++) begin
        if (v_q[e] && a_q[e] == look_addr[s*AW +: AW]) begin
          look_hit[s]           = 1'b1;
          look_hop[s*HW +: HW]  = h_q[e];
          hit_ent[s]            = CW'(e);
        end
      end
    end
  end

  logic [CW-1:0] ref_age, slot_e;
  logic          fill_found, free_found;

  always_comb begin
    v_n = v_q; a_n = a_q; h_n = h_q; age_n = age_q;
    ref_age = '0; slot_e = '0; fill_found = 1'b0; free_found = 1'b0;
    // uses by accepted hits, slot order
    for (int s = 0; s < W; s++) begin
      if (touch[s] && look_hit[s]) begin
        ref_age = age_n[hit_ent[s]];
        for (int e = 0; e < CE; e++)
          if (age_n[e] < ref_age) age_n[e] = age_n[e] + 1'b1;
        age_n[hit_ent[s]] = '0;
      end
    end
    // fill: same address, else lowest free entry, else oldest entry
    if (fill_valid) begin
      for (int e = 0; e < CE; e++)
        if (v_q[e] && a_q[e] == fill_addr) begin
          slot_e = CW'(e); fill_found = 1'b1;
        end
      if (!fill_found) begin
        for (int e = CE - 1; e >= 0; e--)
          if (!v_q[e]) begin
            slot_e = CW'(e); free_found = 1'b1;
          end
        if (!free_found)
          for (int e = 0; e < CE; e++)
            if (age_n[e] == CW'(CE - 1)) slot_e = CW'(e);
      end
      v_n[slot_e] = 1'b1;
      a_n[slot_e] = fill_addr;
      h_n[slot_e] = fill_hop;
      ref_age = age_n[slot_e];
      for (int e = 0; e < CE; e++)
        if (age_n[e] < ref_age) age_n[e] = age_n[e] + 1'b1;
      age_n[slot_e] = '0;
    end
    // route update after fill, no effect on recency
    if (upd_valid) begin
      for (int e = 0; e < CE; e++)
        if (v_n[e] && a_n[e] == upd_addr) begin
          if (upd_kill) v_n[e] = 1'b0;
          else          h_n[e] = upd_hop;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int e = 0; e < CE; e++) begin
        a_q[e]   <= '0;
        h_q[e]   <= '0;
        age_q[e] <= CW'(e);
      end
    end else begin
      v_q <= v_n; a_q <= a_n; h_q <= h_n; age_q <= age_n;
    end
  end
endmodule

// File: rtl/lpm_dsp_seltbl.sv
module lpm_dsp_seltbl #(
  parameter int W  = 4,
  parameter int AW = 32,
  parameter int IB = 8,
  parameter int NQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W*AW-1:0] rd_addr,
  output logic [W*((NQ > 1) ? $clog2(NQ) : 1)-1:0] rd_queue,
  input  logic            wr_en,
  input  logic [IB-1:0]   wr_idx,
  input  logic [((NQ > 1) ? $clog2(NQ) : 1)-1:0] wr_queue
);
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int DEPTH = 1 << IB;

  logic [QW-1:0] mem [DEPTH];

  for (genvar s = 0; s < W; s++) begin : g_rd
    assign rd_queue[s*QW +: QW] = mem[rd_addr[s*AW + AW - 1 -: IB]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_queue;
    end
  end
endmodule

// File: rtl/lpm_dsp_steer.sv
module lpm_dsp_steer
  import lpm_dispatch_pkg::*;
#(
  parameter int W  = 4,
  parameter int NQ = 4,
  parameter int QD = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_valid,
  input  logic [W-1:0] hit,
  input  logic [W*((NQ > 1) ? $clog2(NQ) : 1)-1:0] home,
  input  logic [NQ-1:0] deq,
  output logic [W-1:0] ready,
  output logic [W*((NQ > 1) ? $clog2(NQ) : 1)-1:0] pick,
  output logic [W*$clog2(QD + 1)-1:0] delay
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int OW = $clog2(QD + 1);

  logic [OW-1:0] occ_q [NQ];
  logic [OW-1:0] run   [NQ];
  logic [QW-1:0] home_s, low_s, pick_s;
  logic          blocked;

  function automatic logic [QW-1:0] least_queue(input logic [OW-1:0] occ [NQ]);
    logic [QW-1:0] best;
    best = '0;
    for (int q = 1; q < NQ; q++)
      if (occ[q] < occ[best]) best = QW'(q);
    return best;
  endfunction

  always_comb begin
    run = occ_q;
    blocked = 1'b0;
    ready = '0; pick = '0; delay = '0;
    home_s = '0; low_s = '0; pick_s = '0;
    for (int s = 0; s < W; s++) begin
      home_s = home[s*QW +: QW];
      low_s  = least_queue(run);
      pick_s = hit[s] ? low_s : home_s;
      pick[s*QW +: QW]  = pick_s;
      delay[s*OW +: OW] = hit[s] ? OW'(occ_gap(int'(run[home_s]), int'(run[low_s]))) : '0;
      ready[s] = !blocked && (run[pick_s] != OW'(QD));
      if (in_valid[s]) begin
        if (ready[s]) run[pick_s] = run[pick_s] + 1'b1;
        else          blocked = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (!rst_n) occ_q[q] <= '0;
      else        occ_q[q] <= run[q] - OW'(deq[q] && (occ_q[q] != '0));
    end
  end
endmodule

// File: rtl/lpm_dispatch.sv
module lpm_dispatch
  import lpm_dispatch_pkg::*;
#(
  parameter int W  = 4,
  parameter int NQ = 4,
  parameter int AW = 32,
  parameter int IB = 8,
  parameter int HW = 8,
  parameter int CE = 8,
  parameter int QD = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    in_valid,
  output logic [W-1:0]    in_ready,
  input  logic [W*AW-1:0] in_addr,
  input  logic [NQ-1:0]   deq,
  input  logic            fill_valid,
  input  logic [AW-1:0]   fill_addr,
  input  logic [HW-1:0]   fill_hop,
  input  logic            upd_valid,
  input  logic            upd_kill,
  input  logic [AW-1:0]   upd_addr,
  input  logic [HW-1:0]   upd_hop,
  input  logic            tbl_we,
  input  logic [IB-1:0]   tbl_idx,
  input  logic [((NQ > 1) ? $clog2(NQ) : 1)-1:0] tbl_queue,
  output logic [W-1:0]    out_valid,
  output logic [W-1:0]    out_hit,
  output logic [W*((NQ > 1) ? $clog2(NQ) : 1)-1:0] out_queue,
  output logic [W*HW-1:0] out_hop,
  output logic [W*$clog2(QD + 1)-1:0] out_delay,
  output logic [W*$clog2(W + 1)-1:0]  out_tag
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int OW = $clog2(QD + 1);
  localparam int TW = $clog2(W + 1);

  logic [W-1:0]    hit, acc;
  logic [W*HW-1:0] hop;
  logic [W*QW-1:0] home, pick;
  logic [W*OW-1:0] dly;

  assign acc = in_valid & in_ready;

  lpm_dsp_cache #(.W(W), .AW(AW), .HW(HW), .CE(CE)) cache_i (
    .clk, .rst_n,
    .look_addr(in_addr), .look_hit(hit), .look_hop(hop), .touch(acc),
    .fill_valid, .fill_addr, .fill_hop,
    .upd_valid, .upd_kill, .upd_addr, .upd_hop
  );

  lpm_dsp_seltbl #(.W(W), .AW(AW), .IB(IB), .NQ(NQ)) tbl_i (
    .clk, .rst_n,
    .rd_addr(in_addr), .rd_queue(home),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_queue(tbl_queue)
  );

  lpm_dsp_steer #(.W(W), .NQ(NQ), .QD(QD)) steer_i (
    .clk, .rst_n,
    .in_valid, .hit, .home, .deq,
    .ready(in_ready), .pick, .delay(dly)
  );

  for (genvar s = 0; s < W; s++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid[s]             <= 1'b0;
        out_hit[s]               <= 1'b0;
        out_queue[s*QW +: QW]    <= '0;
        out_hop[s*HW +: HW]      <= '0;
        out_delay[s*OW +: OW]    <= '0;
        out_tag[s*TW +: TW]      <= '0;
      end else begin
        out_valid[s]             <= acc[s];
        out_hit[s]               <= acc[s] & hit[s];
        out_queue[s*QW +: QW]    <= acc[s] ? pick[s*QW +: QW] : '0;
        out_hop[s*HW +: HW]      <= (acc[s] && hit[s]) ? hop[s*HW +: HW] : '0;
        out_delay[s*OW +: OW]    <= acc[s] ? dly[s*OW +: OW] : '0;
        out_tag[s*TW +: TW]      <= acc[s] ? TW'(slot_tag(s)) : '0;
      end
    end
  end
endmodule

// File: rtl/lpm_dispatch_chk.sv
module lpm_dispatch_chk #(
  parameter int W  = 4,
  parameter int HW = 8,
  parameter int OW = 4,
  parameter int TW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    in_valid,
  input logic [W-1:0]    in_ready,
  input logic [W-1:0]    out_valid,
  input logic [W-1:0]    out_hit,
  input logic [W*HW-1:0] out_hop,
  input logic [W*OW-1:0] out_delay,
  input logic [W*TW-1:0] out_tag
);
  for (genvar s = 0; s < W; s++) begin : g_slot
    // R3
    miss_zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[s] && !out_hit[s]) |-> (out_delay[s*OW +: OW] == '0 && out_hop[s*HW +: HW] == '0));
    // R4
    tag_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[s] |-> (out_tag[s*TW +: TW] == TW'(s + 1)));
    // R4
    accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[s] && in_ready[s]) |=> out_valid[s]);
    // R4
    refused_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid[s] && in_ready[s]) |=> !out_valid[s]);
    if (s < W - 1) begin : g_chain
      // R9
      block_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[s] && !in_ready[s]) |-> !in_ready[s+1]);
    end
  end
endmodule

bind lpm_dispatch lpm_dispatch_chk #(.W(W), .HW(HW), .OW(OW), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_hit(out_hit), .out_hop(out_hop),
  .out_delay(out_delay), .out_tag(out_tag)
);

// File: tb/lpm_dispatch_tb.sv
module lpm_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4, NQ = 4, AW = 32, IB = 8, HW = 8, CE = 4, QD = 6;
  localparam int QW = 2, OW = 3, TW = 3;
  localparam int POOL = 10;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] in_valid = '0, in_ready;
  logic [W*AW-1:0] in_addr = '0;
  logic [NQ-1:0] deq = '0;
  logic fill_valid = 0, upd_valid = 0, upd_kill = 0, tbl_we = 0;
  logic [AW-1:0] fill_addr = '0, upd_addr = '0;
  logic [HW-1:0] fill_hop = '0, upd_hop = '0;
  logic [IB-1:0] tbl_idx = '0;
  logic [QW-1:0] tbl_queue = '0;
  logic [W-1:0] out_valid, out_hit;
  logic [W*QW-1:0] out_queue;
  logic [W*HW-1:0] out_hop;
  logic [W*OW-1:0] out_delay;
  logic [W*TW-1:0] out_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_dispatch #(.W(W), .NQ(NQ), .AW(AW), .IB(IB), .HW(HW), .CE(CE), .QD(QD)) dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_addr, .deq,
    .fill_valid, .fill_addr, .fill_hop, .upd_valid, .upd_kill, .upd_addr, .upd_hop,
    .tbl_we, .tbl_idx, .tbl_queue,
    .out_valid, .out_hit, .out_queue, .out_hop, .out_delay, .out_tag);

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int occ [NQ];
  int run_after [NQ];
  int tbl [256];
  logic [AW-1:0] lru [$];
  logic [HW-1:0] hopm [logic [AW-1:0]];
  logic [AW-1:0] pool [POOL];
  bit pv [W];
  bit ph [W];
  int pq [W], phop [W], pd [W];
  bit exp_rdy [W];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find(input logic [AW-1:0] a);
    foreach (lru[i]) if (lru[i] == a) return i;
    return -1;
  endfunction

  task automatic model_eval();
    int run [NQ];
    bit blocked;
    blocked = 0;
    for (int q = 0; q < NQ; q++) run[q] = occ[q];
    for (int s = 0; s < W; s++) begin
      logic [AW-1:0] a;
      int home, low, tgt;
      bit h, r;
      a = in_addr[s*AW +: AW];
      h = (find(a) >= 0);
      home = tbl[a[AW-1 -: IB]];
      low = 0;
      for (int q = 1; q < NQ; q++) if (run[q] < run[low]) low = q;
      tgt = h ? low : home;
      r = !blocked && run[tgt] < QD;
      exp_rdy[s] = r;
      pv[s] = 0;
      if (in_valid[s]) begin
        if (r) begin
          pv[s] = 1; ph[s] = h; pq[s] = tgt;
          phop[s] = h ? int'(hopm[a]) : 0;
          pd[s] = h ? run[home] - run[low] : 0;
          run[tgt]++;
        end else blocked = 1;
      end
    end
    for (int q = 0; q < NQ; q++) run_after[q] = run[q];
  endtask

  task automatic model_commit();
    for (int s = 0; s < W; s++)
      if (pv[s] && ph[s]) begin
        logic [AW-1:0] a;
        a = in_addr[s*AW +: AW];
        lru.delete(find(a));
        lru.push_front(a);
      end
    if (fill_valid) begin
      if (find(fill_addr) >= 0) lru.delete(find(fill_addr));
      else if (lru.size() == CE) begin
        hopm.delete(lru[lru.size()-1]);
        void'(lru.pop_back());
      end
      lru.push_front(fill_addr);
      hopm[fill_addr] = fill_hop;
    end
    if (upd_valid && find(upd_addr) >= 0) begin
      if (upd_kill) begin
        lru.delete(find(upd_addr));
        hopm.delete(upd_addr);
      end else hopm[upd_addr] = upd_hop;
    end
    if (tbl_we) tbl[tbl_idx] = int'(tbl_queue);
    for (int q = 0; q < NQ; q++)
      occ[q] = run_after[q] - ((deq[q] && occ[q] > 0) ? 1 : 0);
  endtask

  task automatic check_outputs();
    for (int s = 0; s < W; s++) begin
      chk("R4 out_valid", int'(out_valid[s]), int'(pv[s]));
      if (pv[s] && out_valid[s]) begin
        chk("R5 R6 R7 out_hit", int'(out_hit[s]), int'(ph[s]));
        chk(ph[s] ? "R2 queue(hit)" : "R1 R10 queue(miss)", int'(out_queue[s*QW +: QW]), pq[s]);
        chk("R3 R5 R7 hop", int'(out_hop[s*HW +: HW]), phop[s]);
        chk("R3 delay", int'(out_delay[s*OW +: OW]), pd[s]);
        chk("R4 tag", int'(out_tag[s*TW +: TW]), s + 1);
      end
    end
  endtask

  task automatic cycle(input bit do_tbl, input int tbl_i);
    @(negedge clk);
    check_outputs();
    for (int s = 0; s < W; s++) begin
      in_valid[s] = ($urandom_range(9) < 7);
      in_addr[s*AW +: AW] = pool[$urandom_range(POOL-1)];
    end
    for (int q = 0; q < NQ; q++) deq[q] = ($urandom_range(9) < 3);
    fill_valid = ($urandom_range(9) < 4);
    fill_addr  = pool[$urandom_range(POOL-1)];
    fill_hop   = HW'($urandom);
    upd_valid  = ($urandom_range(9) < 1);
    upd_kill   = $urandom_range(1);
    upd_addr   = pool[$urandom_range(POOL-1)];
    upd_hop    = HW'($urandom);
    tbl_we     = do_tbl;
    tbl_idx    = IB'(tbl_i);
    tbl_queue  = QW'($urandom);
    #1;
    model_eval();
    for (int s = 0; s < W; s++)
      chk("R8 R9 in_ready", int'(in_ready[s]), int'(exp_rdy[s]));
    @(posedge clk);
    model_commit();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tbl[i] = 0;
    for (int q = 0; q < NQ; q++) occ[q] = 0;
    for (int s = 0; s < W; s++) pv[s] = 0;
    for (int i = 0; i < POOL; i++) pool[i] = $urandom;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10: idle outputs and empty queues right after reset
    chk("R10 out_valid idle", int'(out_valid), 0);
    chk("R10 in_ready all", int'(in_ready), (1 << W) - 1);
    // phase 1: table still at reset contents
    for (int i = 0; i < 50; i++) cycle(0, 0);
    // phase 2: program every table entry a pool address can use
    for (int i = 0; i < POOL; i++) cycle(1, int'(pool[i][AW-1 -: IB]));
    for (int i = 0; i < 256; i++) cycle(1, i);
    // phase 3: mixed traffic with sporadic table writes
    for (int i = 0; i < 3000; i++)
      cycle($urandom_range(19) == 0, int'(pool[$urandom_range(POOL-1)][AW-1 -: IB]));
    @(negedge clk);
    check_outputs();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule